// File: doc/BRIEF.md
# Per-Channel Colour Correction Lookup Engine

This block sits in a parallel pixel path and sets the display's white point. Each red, green and blue component selects an entry in its own 256-entry, 8-bit table, and that entry replaces the component. Table contents and a small control word reach the block through a register port with page, address, write-data and read-data lines. The tables can be read back through the same port. The pixel path adds exactly one register stage. The data-enable and both sync strobes go through the same stage, so they stay aligned with the pixels.

After reset the host must fill the tables in a fixed order: every red entry from index 0 up to 255, then every green entry, then every blue entry. Only then does correction take effect. Once this first load is complete, the tables refuse writes unless the host sets a reload-enable bit. With reload enabled, the host may rewrite any entries while correction stays on. Host writes always land in a shadow copy of the tables. The copy that drives pixels is refreshed from the shadow at a frame boundary, so a frame never shows a mix of old and new values. When correction is not running, the refresh happens at once.

There is also a 6-bit input mode. In this mode the two low input bits are ignored when forming the table index. The result is then either cut to 6 bits, or passed at full width together with a flag that asks a later dithering stage to reduce it.

Top module: `clut_engine`

## Requirements
- R1: After reset, every pixel output, strobe output and the dither flag are 0. Reading the status word (page 3, address 1) returns 0.
- R2: Writes on pages 0, 1 and 2 select the red, green and blue tables. The first load is accepted only in this order: page 0 addresses 0 to 255, then page 1 addresses 0 to 255, then page 2 addresses 0 to 255. Status bit 0 (load done) becomes 1 after the last blue entry is written and then stays 1.
- R3: Before the load is done, a table write whose page or address differs from the next expected one sets status bit 1 (sequence error). That write and every later table write are refused. Load done never becomes 1 until reset.
- R4: After the load is done, table writes are refused while control bit 1 (reload enable) is 0. Read-back then still shows the earlier contents.
- R5: A read strobe with a page and address places data in cfg_rdata one cycle later. Pages 0 to 2 return the table entry last accepted by a write. Page 3 address 0 returns the control word: bit 0 enable, bit 1 reload enable, bit 2 six-bit mode, bit 3 wide output. Page 3 address 1 returns the status word.
- R6: While control bit 0 is 0, or before the load is done, each output component equals its input component one cycle earlier.
- R7: When correction is on and bit 2 is 0, each output component equals its own table's entry at the input value, one cycle later. The dither flag is 0.
- R8: When correction is on, bit 2 is 1 and bit 3 is 0, the index is the input with its two low bits forced to 0. The output is the entry with its two low bits forced to 0.
- R9: When correction is on and bits 2 and 3 are both 1, the index is formed as in R8. The output is the full 8-bit entry, and the dither flag is 1.
- R10: The data-enable, horizontal-sync and vertical-sync outputs equal their inputs one cycle earlier.
- R11: While correction is on, an accepted table write first affects pixels sampled in the cycle after vertical sync rises. Pixels sampled up to and including the cycle in which vertical sync rises use the old contents.
- R12: When correction is enabled in the cycle after the load completes, the very next pixel is already corrected with the loaded contents, with no wait for a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pixel path and the register port |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_page | input | 2 | 0 red, 1 green, 2 blue, 3 control/status |
| cfg_addr | input | 8 | Table index, or register address on page 3 |
| cfg_wdata | input | 8 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Read data, valid the cycle after cfg_rd |
| pix_r_i | input | 8 | Red component in |
| pix_g_i | input | 8 | Green component in |
| pix_b_i | input | 8 | Blue component in |
| pix_de_i | input | 1 | Data enable in |
| pix_hs_i | input | 1 | Horizontal sync in |
| pix_vs_i | input | 1 | Vertical sync in, active high |
| pix_r_o | output | 8 | Red component out |
| pix_g_o | output | 8 | Green component out |
| pix_b_o | output | 8 | Blue component out |
| pix_de_o | output | 1 | Data enable out |
| pix_hs_o | output | 1 | Horizontal sync out |
| pix_vs_o | output | 1 | Vertical sync out |
| dither_req_o | output | 1 | Asks the next stage to reduce the wide result to 6 bits |

## Verification
The assertions assume that the host never raises write and read in the same cycle. They also assume that vertical sync is a level held for at least one cycle, so that its rising edge marks a frame boundary. The stimulus changes inputs only on the falling clock edge. It issues one register access at a time and raises vertical sync only for a short burst in the reload test. The sequence-error properties assume that a reset follows before a new load is tried; the error phases of the bench reset the block before each new attempt.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int unsigned CH_COUNT = 3;
    localparam int unsigned COMP_BITS = 8;
    localparam int unsigned NARROW_BITS = 6;

    typedef enum logic [1:0] {
        PG_RED   = 2'd0,
        PG_GREEN = 2'd1,
        PG_BLUE  = 2'd2,
        PG_CTRL  = 2'd3
    } page_e;

    typedef struct packed {
        logic wide;
        logic six_bit;
        logic reload;
        logic enable;
    } ctrl_t;

    localparam int unsigned CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/clut_bank.sv
module clut_bank #(
    parameter int unsigned W  = 8,
    parameter int unsigned IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_val,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_val,
    input  logic          xfer,
    input  logic [IW-1:0] lk_idx,
    output logic [W-1:0]  lk_val
);
    localparam int unsigned DEPTH = 1 << IW;

    // host-facing copy and the copy the pixel path reads
    logic [W-1:0] shadow_d [DEPTH];
    logic [W-1:0] shadow_q [DEPTH];
    logic [W-1:0] active_d [DEPTH];
    logic [W-1:0] active_q [DEPTH];

    always_comb begin
        shadow_d = shadow_q;
        active_d = xfer ? shadow_q : active_q;
        if (wr_en) begin
            shadow_d[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                shadow_q[i] <= '0;
                active_q[i] <= '0;
            end
        end else begin
            shadow_q <= shadow_d;
            active_q <= active_d;
        end
    end

    assign rd_val = shadow_q[rd_idx];
    assign lk_val = active_q[lk_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> shadow_q[$past(wr_idx)] == $past(wr_val)); // R5

    AST_COPY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> active_q[$past(lk_idx)] == $past(shadow_q[lk_idx])); // R11

endmodule

// File: rtl/clut_cfg.sv
module clut_cfg
    import clut_pkg::*;
#(
    parameter int unsigned W   = 8,
    parameter int unsigned IW  = 8,
    parameter int unsigned NCH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              cfg_page,
    input  logic [IW-1:0]           cfg_addr,
    input  logic [CTRL_BITS-1:0]    ctrl_wdata,
    input  logic                    cfg_wr,
    input  logic                    cfg_rd,
    output logic [W-1:0]            cfg_rdata,
    input  logic [NCH-1:0][W-1:0]   tbl_rd_val,
    input  logic                    vs_start,
    output logic [NCH-1:0]          tbl_we,
    output logic                    xfer,
    output logic                    corr_on,
    output logic                    six_bit,
    output logic                    wide
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic          done;
        logic          err;
        logic          dirty;
        logic [1:0]    exp_pg;
        logic [IW-1:0] exp_ad;
        logic [W-1:0]  rdata;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    accept;
    logic    tbl_access;

    always_comb begin
        st_d       = st_q;
        tbl_we     = '0;
        accept     = 1'b0;
        tbl_access = cfg_wr && (cfg_page != PG_CTRL);

        if (cfg_wr && cfg_page == PG_CTRL && cfg_addr == '0) begin
            st_d.ctrl = ctrl_t'(ctrl_wdata);
        end

        if (tbl_access) begin
            if (!st_q.done) begin
                if (!st_q.err) begin
                    if (cfg_page == st_q.exp_pg && cfg_addr == st_q.exp_ad) begin
                        accept      = 1'b1;
                        st_d.exp_ad = st_q.exp_ad + 1'b1;
                        if (st_q.exp_ad == '1) begin
                            if (st_q.exp_pg == PG_BLUE) begin
                                st_d.done = 1'b1;
                            end else begin
                                st_d.exp_pg = st_q.exp_pg + 2'd1;
                            end
                        end
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
            end else if (st_q.ctrl.reload) begin
                accept = 1'b1;
            end
        end

        if (accept) begin
            tbl_we[cfg_page] = 1'b1;
        end

        corr_on = st_q.ctrl.enable & st_q.done;
        xfer    = st_q.dirty & (vs_start | ~corr_on);
        st_d.dirty = (st_q.dirty & ~xfer) | accept;

        if (cfg_rd) begin
            if (cfg_page == PG_CTRL) begin
                if (cfg_addr == '0) begin
                    st_d.rdata = {{(W-CTRL_BITS){1'b0}}, st_q.ctrl};
                end else if (cfg_addr == IW'(1)) begin
                    st_d.rdata = {{(W-2){1'b0}}, st_q.err, st_q.done};
                end else begin
                    st_d.rdata = '0;
                end
            end else begin
                st_d.rdata = tbl_rd_val[cfg_page];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata = st_q.rdata;
    assign six_bit   = st_q.ctrl.six_bit;
    assign wide      = st_q.ctrl.wide;

    AST_LOCKED_TABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !st_q.ctrl.reload) |-> (tbl_we == '0)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err); // R3

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.err); // R3

    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> st_q.done); // R2

    AST_ONE_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tbl_we)); // R2

    AST_SEAMLESS: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_on && xfer) |-> vs_start); // R11

endmodule

// File: rtl/clut_pix.sv
module clut_pix #(
    parameter int unsigned W      = 8,
    parameter int unsigned IW     = 8,
    parameter int unsigned NCH    = 3,
    parameter int unsigned NARROW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0][W-1:0]  pix_i,
    input  logic                   de_i,
    input  logic                   hs_i,
    input  logic                   vs_i,
    output logic [NCH-1:0][IW-1:0] lk_idx,
    input  logic [NCH-1:0][W-1:0]  lk_val,
    input  logic                   corr_on,
    input  logic                   six_bit,
    input  logic                   wide,
    output logic [NCH-1:0][W-1:0]  pix_o,
    output logic                   de_o,
    output logic                   hs_o,
    output logic                   vs_o,
    output logic                   dither_req,
    output logic                   vs_start
);
    localparam int unsigned DROP = W - NARROW;

    typedef struct packed {
        logic [NCH-1:0][W-1:0] pix;
        logic                  de;
        logic                  hs;
        logic                  vs;
        logic                  dr;
    } pix_st_t;

    pix_st_t st_d, st_q;
    logic [NCH-1:0][W-1:0] mapped;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign lk_idx[c] = six_bit ? {pix_i[c][W-1:DROP], {DROP{1'b0}}} : pix_i[c];
        assign mapped[c] = (six_bit && !wide) ? {lk_val[c][W-1:DROP], {DROP{1'b0}}}
                                              : lk_val[c];

        AST_NARROW_LSB: assert property (@(posedge clk) disable iff (!rst_n)
            (corr_on && six_bit && !wide) |=> (pix_o[c][DROP-1:0] == '0)); // R8
    end

    always_comb begin
        st_d     = st_q;
        st_d.pix = corr_on ? mapped : pix_i;
        st_d.de  = de_i;
        st_d.hs  = hs_i;
        st_d.vs  = vs_i;
        st_d.dr  = corr_on & six_bit & wide;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o      = st_q.pix;
    assign de_o       = st_q.de;
    assign hs_o       = st_q.hs;
    assign vs_o       = st_q.vs;
    assign dither_req = st_q.dr;
    assign vs_start   = vs_i & ~st_q.vs;

    AST_STROBE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({de_o, hs_o, vs_o} == $past({de_i, hs_i, vs_i}))); // R10

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_on |=> (pix_o == $past(pix_i))); // R6

    AST_DITHER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dither_req |-> $past(corr_on && wide)); // R9

endmodule

// File: rtl/clut_engine.sv
module clut_engine
    import clut_pkg::*;
#(
    parameter int unsigned COMP_W = COMP_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_page,
    input  logic [COMP_W-1:0] cfg_addr,
    input  logic [COMP_W-1:0] cfg_wdata,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    output logic [COMP_W-1:0] cfg_rdata,
    input  logic [COMP_W-1:0] pix_r_i,
    input  logic [COMP_W-1:0] pix_g_i,
    input  logic [COMP_W-1:0] pix_b_i,
    input  logic              pix_de_i,
    input  logic              pix_hs_i,
    input  logic              pix_vs_i,
    output logic [COMP_W-1:0] pix_r_o,
    output logic [COMP_W-1:0] pix_g_o,
    output logic [COMP_W-1:0] pix_b_o,
    output logic              pix_de_o,
    output logic              pix_hs_o,
    output logic              pix_vs_o,
    output logic              dither_req_o
);
    localparam int unsigned IDX_W = COMP_W;
    localparam int unsigned NCH   = CH_COUNT;

    logic [NCH-1:0][COMP_W-1:0] pix_in, pix_out, rd_val, lk_val;
    logic [NCH-1:0][IDX_W-1:0]  lk_idx;
    logic [NCH-1:0]             tbl_we;
    logic                       xfer, corr_on, six_bit, wide, vs_start;

    assign pix_in = {pix_b_i, pix_g_i, pix_r_i};

    clut_cfg #(.W(COMP_W), .IW(IDX_W), .NCH(NCH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_page   (cfg_page),
        .cfg_addr   (cfg_addr),
        .ctrl_wdata (cfg_wdata[CTRL_BITS-1:0]),
        .cfg_wr     (cfg_wr),
        .cfg_rd     (cfg_rd),
        .cfg_rdata  (cfg_rdata),
        .tbl_rd_val (rd_val),
        .vs_start   (vs_start),
        .tbl_we     (tbl_we),
        .xfer       (xfer),
        .corr_on    (corr_on),
        .six_bit    (six_bit),
        .wide       (wide)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_bank
        clut_bank #(.W(COMP_W), .IW(IDX_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (tbl_we[c]),
            .wr_idx (cfg_addr),
            .wr_val (cfg_wdata),
            .rd_idx (cfg_addr),
            .rd_val (rd_val[c]),
            .xfer   (xfer),
            .lk_idx (lk_idx[c]),
            .lk_val (lk_val[c])
        );
    end

    clut_pix #(.W(COMP_W), .IW(IDX_W), .NCH(NCH), .NARROW(NARROW_BITS)) u_pix (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_i      (pix_in),
        .de_i       (pix_de_i),
        .hs_i       (pix_hs_i),
        .vs_i       (pix_vs_i),
        .lk_idx     (lk_idx),
        .lk_val     (lk_val),
        .corr_on    (corr_on),
        .six_bit    (six_bit),
        .wide       (wide),
        .pix_o      (pix_out),
        .de_o       (pix_de_o),
        .hs_o       (pix_hs_o),
        .vs_o       (pix_vs_o),
        .dither_req (dither_req_o),
        .vs_start   (vs_start)
    );

    assign pix_r_o = pix_out[0];
    assign pix_g_o = pix_out[1];
    assign pix_b_o = pix_out[2];

endmodule

// File: tb/clut_engine_tb.sv
module clut_engine_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_page = '0;
    logic [7:0] cfg_addr = '0, cfg_wdata = '0;
    logic       cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [7:0] cfg_rdata;
    logic [7:0] pr = '0, pg = '0, pb = '0;
    logic       pde = 1'b0, phs = 1'b0, pvs = 1'b0;
    logic [7:0] r_o, g_o, b_o;
    logic       de_o, hs_o, vs_o, dr_o;

    int nchk = 0;
    int nbad = 0;

    always #2 clk = ~clk;

    clut_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_page(cfg_page), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
        .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb),
        .pix_de_i(pde), .pix_hs_i(phs), .pix_vs_i(pvs),
        .pix_r_o(r_o), .pix_g_o(g_o), .pix_b_o(b_o),
        .pix_de_o(de_o), .pix_hs_o(hs_o), .pix_vs_o(vs_o),
        .dither_req_o(dr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] tv(input int c, input int i);
        if (c == 0) return 8'((i * 7 + 3) & 255);
        if (c == 1) return 8'(255 - i);
        return 8'(i) ^ 8'h5A;
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_sh  [3][256];
    logic [7:0] m_act [3][256];
    bit m_en, m_rl, m_six, m_wide, m_done, m_err, m_dirty, m_vsp;
    int m_pg, m_ad;
    logic [7:0] e_pix [3];
    bit e_de, e_hs, e_vs, e_dr;
    logic [7:0] e_rd;
    string e_req;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                for (int i = 0; i < 256; i++) begin
                    m_sh[c][i] = '0;
                    m_act[c][i] = '0;
                end
                e_pix[c] = '0;
            end
            {m_en, m_rl, m_six, m_wide, m_done, m_err, m_dirty, m_vsp} = '0;
            m_pg = 0; m_ad = 0;
            {e_de, e_hs, e_vs, e_dr} = '0;
            e_rd = '0;
            e_req = "R1";
        end else begin
            bit corr;
            logic [7:0] inp [3];
            inp[0] = pr; inp[1] = pg; inp[2] = pb;
            corr = m_en && m_done;
            for (int c = 0; c < 3; c++) begin
                int idx;
                logic [7:0] v;
                idx = m_six ? int'(inp[c] & 8'hFC) : int'(inp[c]);
                v = m_act[c][idx];
                if (!corr) e_pix[c] = inp[c];
                else if (m_six && !m_wide) e_pix[c] = v & 8'hFC;
                else e_pix[c] = v;
            end
            e_req = !corr ? "R6" : (!m_six ? "R7" : (m_wide ? "R9" : "R8"));
            e_de = pde; e_hs = phs; e_vs = pvs;
            e_dr = corr && m_six && m_wide;
            if (cfg_rd) begin
                if (cfg_page == 2'd3)
                    e_rd = (cfg_addr == 0) ? {4'b0, m_wide, m_six, m_rl, m_en}
                         : (cfg_addr == 1) ? {6'b0, m_err, m_done} : 8'h00;
                else
                    e_rd = m_sh[cfg_page][cfg_addr];
            end
            if (m_dirty && ((pvs && !m_vsp) || !corr)) begin
                m_act = m_sh;
                m_dirty = 1'b0;
            end
            if (cfg_wr) begin
                if (cfg_page == 2'd3) begin
                    if (cfg_addr == 0) {m_wide, m_six, m_rl, m_en} = cfg_wdata[3:0];
                end else if (!m_done) begin
                    if (!m_err) begin
                        if (int'(cfg_page) == m_pg && int'(cfg_addr) == m_ad) begin
                            m_sh[cfg_page][cfg_addr] = cfg_wdata;
                            m_dirty = 1'b1;
                            if (m_ad == 255) begin
                                m_ad = 0;
                                if (m_pg == 2) m_done = 1'b1; else m_pg++;
                            end else m_ad++;
                        end else m_err = 1'b1;
                    end
                end else if (m_rl) begin
                    m_sh[cfg_page][cfg_addr] = cfg_wdata;
                    m_dirty = 1'b1;
                end
            end
            m_vsp = pvs;
        end
    end

    // compare on every clock, half a period after the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(r_o == e_pix[0], e_req, r_o, e_pix[0]);
            chk(g_o == e_pix[1], e_req, g_o, e_pix[1]);
            chk(b_o == e_pix[2], e_req, b_o, e_pix[2]);
            chk({de_o, hs_o, vs_o} == {e_de, e_hs, e_vs}, "R10", {de_o, hs_o, vs_o}, {e_de, e_hs, e_vs});
            chk(dr_o == e_dr, "R9", dr_o, e_dr);
            chk(cfg_rdata == e_rd, "R5", cfg_rdata, e_rd);
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------------
    task automatic wr(input int p, input int a, input int d);
        cfg_page = 2'(p); cfg_addr = 8'(a); cfg_wdata = 8'(d); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int p, input int a, output logic [7:0] v);
        cfg_page = 2'(p); cfg_addr = 8'(a); cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
        v = cfg_rdata;
    endtask

    task automatic px(input int r, input int g, input int b, input bit de, input bit hs, input bit vs);
        pr = 8'(r); pg = 8'(g); pb = 8'(b); pde = de; phs = hs; pvs = vs;
        @(negedge clk);
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk({r_o, g_o, b_o, de_o, hs_o, vs_o, dr_o} == '0, "R1", r_o, 0);
        rd(3, 1, v);
        chk(v == 8'h00, "R1", v, 0);

        // R6: pass-through before any load
        px(8'h12, 8'h34, 8'hF7, 1, 0, 0);
        chk(r_o == 8'h12 && g_o == 8'h34 && b_o == 8'hF7, "R6", r_o, 8'h12);

        // R2: ordered first load
        for (int c = 0; c < 3; c++)
            for (int i = 0; i < 256; i++)
                wr(c, i, tv(c, i));
        rd(3, 1, v);
        chk(v == 8'h01, "R2", v, 1);

        // R5: read-back
        rd(0, 5, v);   chk(v == tv(0, 5), "R5", v, tv(0, 5));
        rd(2, 200, v); chk(v == tv(2, 200), "R5", v, tv(2, 200));

        // R4: locked after load
        wr(0, 10, 8'h00);
        rd(0, 10, v);
        chk(v == tv(0, 10), "R4", v, tv(0, 10));

        // R12 / R7: enable, 24-bit lookup
        wr(3, 0, 4'b0001);
        px(10, 20, 30, 1, 0, 0);
        chk(r_o == tv(0, 10) && g_o == tv(1, 20) && b_o == tv(2, 30), "R12", r_o, tv(0, 10));
        px(0, 255, 128, 1, 1, 0);
        chk(r_o == tv(0, 0) && g_o == tv(1, 255) && b_o == tv(2, 128), "R7", g_o, tv(1, 255));
        chk(dr_o == 1'b0, "R7", dr_o, 0);
        px(255, 0, 1, 1, 0, 0);
        chk(r_o == tv(0, 255) && b_o == tv(2, 1), "R7", r_o, tv(0, 255));

        // R8: six-bit narrow output
        wr(3, 0, 4'b0101);
        px(8'h47, 8'hFF, 8'h03, 1, 0, 0);
        chk(r_o == (tv(0, 8'h44) & 8'hFC), "R8", r_o, tv(0, 8'h44) & 8'hFC);
        chk(g_o == (tv(1, 8'hFC) & 8'hFC), "R8", g_o, tv(1, 8'hFC) & 8'hFC);
        chk(b_o == (tv(2, 0) & 8'hFC), "R8", b_o, tv(2, 0) & 8'hFC);

        // R9: six-bit wide output with dither flag
        wr(3, 0, 4'b1101);
        px(8'h47, 8'h81, 8'h02, 1, 0, 0);
        chk(r_o == tv(0, 8'h44) && g_o == tv(1, 8'h80), "R9", r_o, tv(0, 8'h44));
        chk(dr_o == 1'b1, "R9", dr_o, 1);

        // R10: strobe alignment
        px(1, 2, 3, 0, 1, 0);
        chk(de_o == 1'b0 && hs_o == 1'b1 && vs_o == 1'b0, "R10", {de_o, hs_o, vs_o}, 3'b010);

        // R11: seamless reload while correcting
        wr(3, 0, 4'b0011);
        rd(3, 0, v);
        chk(v == 8'h03, "R5", v, 3);
        wr(0, 20, 8'h11);
        wr(1, 7, 8'h22);
        px(20, 7, 0, 1, 0, 0);
        chk(r_o == tv(0, 20) && g_o == tv(1, 7), "R11", r_o, tv(0, 20));
        px(20, 7, 0, 0, 0, 1);
        chk(r_o == tv(0, 20), "R11", r_o, tv(0, 20));
        px(20, 7, 0, 0, 0, 1);
        chk(r_o == 8'h11 && g_o == 8'h22, "R11", r_o, 8'h11);
        px(20, 7, 0, 1, 0, 0);
        rd(0, 20, v);
        chk(v == 8'h11, "R5", v, 8'h11);

        // R6: disabled again -> pass-through
        wr(3, 0, 4'b0000);
        px(20, 7, 9, 1, 0, 0);
        chk(r_o == 8'd20 && g_o == 8'd7 && b_o == 8'd9, "R6", r_o, 20);

        // R3: wrong page first
        reset_dut();
        wr(1, 0, 8'hAA);
        rd(3, 1, v);
        chk(v == 8'h02, "R3", v, 2);
        wr(0, 0, 8'h55);
        rd(0, 0, v);
        chk(v == 8'h00, "R3", v, 0);
        rd(1, 0, v);
        chk(v == 8'h00, "R3", v, 0);

        // R3: skipped address
        reset_dut();
        wr(0, 0, 8'h01);
        wr(0, 2, 8'h02);
        rd(3, 1, v);
        chk(v == 8'h02, "R3", v, 2);
        wr(0, 1, 8'h03);
        rd(0, 1, v);
        chk(v == 8'h00, "R3", v, 0);

        @(negedge clk);
        summary();
    end

endmodule